// File: doc/BRIEF.md
# AHB-Lite Burst Master with Error Abort

This block is a bus master engine for an AHB-Lite style interconnect. A local client hands it a command: a start address, a direction, a beat count, a transfer size and a base write data word. The engine then issues either one SINGLE transfer or an incrementing (INCR) burst, overlapping each address phase with the previous data phase in the usual pipelined way. Read data comes back one beat at a time with its beat index. The client learns the outcome through a one-cycle completion pulse carrying an OK or ERROR status.

When the slave answers any beat with the two-cycle ERROR response, the engine uses the first response cycle to withdraw the transfer that is already waiting in the address phase, replacing it with IDLE. It takes the error on the second cycle, when HREADY is high. It issues no further beats of that command. Beats that had already completed with OKAY keep their effect. The failing address, direction and zero-based beat index are latched in a fault record that stays visible until the client pulses a clear input. While that record is held, new commands are refused. Read errors and write errors follow exactly the same path.

Top module: `ahbm_engine`

## Requirements
- R1: After reset, htrans is IDLE (2'b00), and cmd_busy, cmd_done and flt_valid are all low.
- R2: A cmd_start seen at a clock edge while the engine is idle and holds no fault puts the first beat on the bus after that edge: htrans NONSEQ (2'b10), haddr = cmd_addr, hsize = cmd_size, hwrite = cmd_write, and hburst SINGLE (3'b000) for a one-beat command or INCR (3'b001) for more beats. cmd_busy is then high.
- R3: Each later beat of a burst is SEQ (2'b11) at the previous address plus 2^hsize bytes. The address phase holds haddr and htrans while hready is low and no error is being answered.
- R4: The write data of beat k, driven in that beat's data phase, is cmd_wdata + k.
- R5: Each read beat that completes with OKAY gives a one-cycle rd_valid in the cycle after its completing edge, with rd_data equal to the slave's hrdata and rd_beat equal to k.
- R6: In the second cycle of an ERROR response, htrans is IDLE in place of the queued next beat.
- R7: After an error is accepted (hresp high with hready high), htrans stays IDLE, and no remaining beat of that command is issued. Beats that finished with OKAY before the error keep their effect.
- R8: An accepted error sets flt_valid in the next cycle, with flt_addr, flt_write and flt_beat (zero-based) of the failing beat. The record holds until flt_clear is pulsed.
- R9: Each accepted command produces exactly one cmd_done pulse. cmd_err is 0 for full success and 1 for an aborted command.
- R10: While flt_valid is high, cmd_start is ignored: no transfer is issued and cmd_busy stays low. After a clear, commands are accepted again.
- R11: A read error and a write error both abort and record in the same way, with the direction shown in flt_write (1 = write).
- R12: hprot is the constant set by the PROT parameter (default 4'b0011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Request to begin a command |
| cmd_addr | input | AW | Start byte address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_beats | input | CW | Number of beats (1..MAX_BEATS, 0 treated as 1) |
| cmd_size | input | 3 | Transfer size code, 2^size bytes |
| cmd_wdata | input | DW | Base write data word |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Status with cmd_done: 1 = aborted by ERROR |
| rd_valid | output | 1 | Read beat data valid |
| rd_data | output | DW | Read beat data |
| rd_beat | output | BW | Index of the read beat |
| flt_clear | input | 1 | Clears the fault record |
| flt_valid | output | 1 | Fault record held |
| flt_addr | output | AW | Address of the failing beat |
| flt_write | output | 1 | Direction of the failing beat |
| flt_beat | output | BW | Zero-based index of the failing beat |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Burst type |
| hprot | output | 4 | Constant protection code |
| hwdata | output | DW | Write data |
| hready | input | 1 | Transfer done / slave ready |
| hresp | input | 1 | 1 = ERROR, 0 = OKAY |
| hrdata | input | DW | Read data |

## Verification
The timing of each result is fixed relative to the edge that causes it:
- The first NONSEQ appears one edge after the accepting edge of cmd_start.
- The IDLE that cancels the pipelined beat appears one edge after the first ERROR cycle.
- rd_valid, cmd_done and the fault record appear in the cycle after the edge that completes the beat or accepts the error.

The bench's slave model and monitors sample on the falling edge, so every observed value is the one settled after the rising edge that produced it. The slave logs each accepted transfer, the htrans shown during the second error cycle and every write it commits. The checks compare these logs with the beat list expected from the command, after a few idle cycles have passed in which any stray beat would have appeared.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;
  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;

  // Byte distance between consecutive beats of a given size code.
  function automatic logic [63:0] beat_step(input logic [2:0] sz);
    return 64'd1 << sz;
  endfunction

  // Burst code picked from the number of beats requested.
  function automatic logic [2:0] burst_for(input int unsigned n);
    return (n > 1) ? BU_INCR : BU_SINGLE;
  endfunction
endpackage

// File: rtl/ahbm_addr_seq.sv
module ahbm_addr_seq
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [2:0]    ld_size,
  input  logic [CW-1:0] ld_beats,
  input  logic          push,
  input  logic          cancel,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hsize,
  output logic [BW-1:0] ap_beat,
  output logic          ap_last
);
  logic [BW-1:0] last_idx;

  assign ap_last = (ap_beat == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr    <= '0;
      htrans   <= TR_IDLE;
      hsize    <= '0;
      ap_beat  <= '0;
      last_idx <= '0;
    end else if (load) begin
      haddr    <= ld_addr;
      htrans   <= TR_NSEQ;
      hsize    <= ld_size;
      ap_beat  <= '0;
      last_idx <= (ld_beats == '0) ? '0 : BW'(ld_beats - CW'(1));
    end else if (cancel) begin
      htrans <= TR_IDLE;
    end else if (push) begin
      if (ap_last) begin
        htrans <= TR_IDLE;
      end else begin
        haddr   <= haddr + AW'(beat_step(hsize));
        htrans  <= TR_SEQ;
        ap_beat <= ap_beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ahbm_data_stage.sv
module ahbm_data_stage #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          hready,
  input  logic [AW-1:0] a_addr,
  input  logic          a_write,
  input  logic [BW-1:0] a_beat,
  input  logic          a_last,
  input  logic [DW-1:0] wbase,
  output logic          dp_valid,
  output logic [AW-1:0] dp_addr,
  output logic          dp_write,
  output logic [BW-1:0] dp_beat,
  output logic          dp_last,
  output logic [DW-1:0] hwdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_addr  <= '0;
      dp_write <= 1'b0;
      dp_beat  <= '0;
      dp_last  <= 1'b0;
      hwdata   <= '0;
    end else if (push) begin
      dp_valid <= 1'b1;
      dp_addr  <= a_addr;
      dp_write <= a_write;
      dp_beat  <= a_beat;
      dp_last  <= a_last;
      hwdata   <= wbase + DW'(a_beat);
    end else if (hready) begin
      dp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ahbm_fault_reg.sv
module ahbm_fault_reg #(
  parameter int AW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          clear,
  input  logic [AW-1:0] c_addr,
  input  logic          c_write,
  input  logic [BW-1:0] c_beat,
  output logic          flt_valid,
  output logic [AW-1:0] flt_addr,
  output logic          flt_write,
  output logic [BW-1:0] flt_beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_write <= 1'b0;
      flt_beat  <= '0;
    end else if (capture) begin
      flt_valid <= 1'b1;
      flt_addr  <= c_addr;
      flt_write <= c_write;
      flt_beat  <= c_beat;
    end else if (clear) begin
      flt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ahbm_engine.sv
module ahbm_engine
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MAX_BEATS = 16,
  parameter logic [3:0] PROT = 4'b0011,
  localparam int CW = $clog2(MAX_BEATS + 1),
  localparam int BW = $clog2(MAX_BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_write,
  input  logic [CW-1:0] cmd_beats,
  input  logic [2:0]    cmd_size,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_busy,
  output logic          cmd_done,
  output logic          cmd_err,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [BW-1:0] rd_beat,
  input  logic          flt_clear,
  output logic          flt_valid,
  output logic [AW-1:0] flt_addr,
  output logic          flt_write,
  output logic [BW-1:0] flt_beat,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [3:0]    hprot,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic          hresp,
  input  logic [DW-1:0] hrdata
);
  logic          take, push, err_first, err_seen, beat_ok, cmd_fin;
  logic          ap_active, ap_last;
  logic [BW-1:0] ap_beat;
  logic          dp_valid, dp_write, dp_last;
  logic [AW-1:0] dp_addr;
  logic [BW-1:0] dp_beat;
  logic [DW-1:0] wbase;

  assign hprot     = PROT;
  assign ap_active = (htrans != TR_IDLE);
  assign take      = cmd_start && !cmd_busy && !flt_valid;
  assign err_first = dp_valid && hresp && !hready;
  assign err_seen  = dp_valid && hresp && hready;
  assign beat_ok   = dp_valid && hready && !hresp;
  assign push      = hready && ap_active && !err_seen;
  assign cmd_fin   = err_seen || (beat_ok && dp_last);

  ahbm_addr_seq #(.AW(AW), .CW(CW), .BW(BW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(take), .ld_addr(cmd_addr),
    .ld_size(cmd_size), .ld_beats(cmd_beats), .push(push),
    .cancel(err_first || err_seen), .haddr(haddr), .htrans(htrans),
    .hsize(hsize), .ap_beat(ap_beat), .ap_last(ap_last)
  );

  ahbm_data_stage #(.AW(AW), .DW(DW), .BW(BW)) u_data (
    .clk(clk), .rst_n(rst_n), .push(push), .hready(hready),
    .a_addr(haddr), .a_write(hwrite), .a_beat(ap_beat), .a_last(ap_last),
    .wbase(wbase), .dp_valid(dp_valid), .dp_addr(dp_addr),
    .dp_write(dp_write), .dp_beat(dp_beat), .dp_last(dp_last),
    .hwdata(hwdata)
  );

  ahbm_fault_reg #(.AW(AW), .BW(BW)) u_fault (
    .clk(clk), .rst_n(rst_n), .capture(err_seen), .clear(flt_clear),
    .c_addr(dp_addr), .c_write(dp_write), .c_beat(dp_beat),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_write(flt_write),
    .flt_beat(flt_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_busy <= 1'b0;
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
      hwrite   <= 1'b0;
      hburst   <= BU_SINGLE;
      wbase    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_beat  <= '0;
    end else begin
      cmd_done <= cmd_fin;
      cmd_err  <= err_seen;
      rd_valid <= beat_ok && !dp_write;
      if (beat_ok && !dp_write) begin
        rd_data <= hrdata;
        rd_beat <= dp_beat;
      end
      if (take) begin
        cmd_busy <= 1'b1;
        hwrite   <= cmd_write;
        hburst   <= burst_for(int'(cmd_beats));
        wbase    <= cmd_wdata;
      end else if (cmd_fin) begin
        cmd_busy <= 1'b0;
      end
    end
  end

  // R2: a newly started command opens with NONSEQ
  p_first_nonseq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> htrans == TR_NSEQ);

  // R3: address phase held while the slave stretches a good beat
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_active && !hready && !(dp_valid && hresp)) |=> ($stable(haddr) && $stable(htrans)));

  // R6: first error cycle withdraws the queued beat
  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_first |=> htrans == TR_IDLE);

  // R7: nothing issued after an accepted error
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |=> (htrans == TR_IDLE && !cmd_busy));

  // R8: accepted error produces a record, held until cleared
  p_rec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |=> flt_valid);
  p_flt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clear) |=> (flt_valid && $stable(flt_addr) && $stable(flt_beat)));

  // R9: one done pulse per command
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  // R10: no bus activity starts while a fault is held
  p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> htrans == TR_IDLE);
endmodule

// File: tb/ahbm_engine_test.sv
`timescale 1ns/1ps
module ahbm_engine_test;
  localparam int AW = 32, DW = 32, MB = 16;
  localparam int CW = $clog2(MB + 1), BW = $clog2(MB);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cmd_start, cmd_write, flt_clear;
  logic [AW-1:0] cmd_addr;
  logic [CW-1:0] cmd_beats;
  logic [2:0]    cmd_size;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_busy, cmd_done, cmd_err, rd_valid;
  logic [DW-1:0] rd_data;
  logic [BW-1:0] rd_beat;
  logic          flt_valid, flt_write;
  logic [AW-1:0] flt_addr;
  logic [BW-1:0] flt_beat;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic          hwrite;
  logic [2:0]    hsize, hburst;
  logic [3:0]    hprot;
  logic [DW-1:0] hwdata;
  logic          hready = 1'b1;
  logic          hresp = 1'b0;
  logic [DW-1:0] hrdata = '0;

  ahbm_engine #(.AW(AW), .DW(DW), .MAX_BEATS(MB)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_beats(cmd_beats), .cmd_size(cmd_size),
    .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .cmd_err(cmd_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_beat(rd_beat), .flt_clear(flt_clear), .flt_valid(flt_valid),
    .flt_addr(flt_addr), .flt_write(flt_write), .flt_beat(flt_beat),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hprot(hprot), .hwdata(hwdata), .hready(hready),
    .hresp(hresp), .hrdata(hrdata)
  );

  // ---------------- slave model (falling-edge sampled) ----------------
  logic [DW-1:0] mem [16];
  logic          s_act = 1'b0, s_write = 1'b0, s_err = 1'b0;
  logic [AW-1:0] s_addr = '0;
  int            s_cnt = 0;
  int            waits = 0;
  logic          bad_en = 1'b0;
  logic [AW-1:0] bad_addr = '0;
  logic [1:0]    p_trans = 2'b00;
  logic [AW-1:0] p_addr = '0;
  logic          p_write = 1'b0;
  logic [2:0]    p_burst = 3'b000;
  logic [DW-1:0] hw_prev = '0;
  logic [AW-1:0] lg_addr [64];
  logic [1:0]    lg_trans [64];
  logic [2:0]    lg_burst [64];
  int            log_n = 0;
  logic [1:0]    cancel_trans = 2'b11;
  int            cancel_n = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      s_act = 1'b0; s_cnt = 0; p_trans = 2'b00;
      hready = 1'b1; hresp = 1'b0;
    end else begin
      if (hready) begin
        if (s_act && s_write && !s_err) mem[s_addr[5:2]] = hw_prev;
        s_act = p_trans[1]; s_addr = p_addr; s_write = p_write;
        s_err = bad_en && (p_addr == bad_addr); s_cnt = 0;
        if (p_trans[1] && log_n < 64) begin
          lg_addr[log_n] = p_addr; lg_trans[log_n] = p_trans;
          lg_burst[log_n] = p_burst; log_n++;
        end
      end else begin
        s_cnt++;
      end
      p_trans = htrans; p_addr = haddr; p_write = hwrite;
      p_burst = hburst; hw_prev = hwdata;
      if (!s_act) begin
        hready = 1'b1; hresp = 1'b0;
      end else if (s_err) begin
        hresp = 1'b1; hready = (s_cnt != 0);
        if (s_cnt == 1) begin cancel_trans = htrans; cancel_n++; end
      end else begin
        hresp = 1'b0; hready = (s_cnt >= waits); hrdata = mem[s_addr[5:2]];
      end
    end
  end

  // ---------------- output monitor ----------------
  logic [DW-1:0] rd_buf [MB];
  int rd_n = 0, done_n = 0;
  logic done_err = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin rd_buf[rd_beat] = rd_data; rd_n++; end
      if (cmd_done) begin done_n++; done_err = cmd_err; end
    end
  end

  // ---------------- checking helpers ----------------
  int n_chk = 0, n_bad = 0;
  int lg0, d0, r0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic w, input int nb,
                       input logic [2:0] sz, input logic [DW-1:0] wd);
    lg0 = log_n; d0 = done_n; r0 = rd_n;
    for (int k = 0; k < MB; k++) rd_buf[k] = '0;
    cmd_addr = a; cmd_write = w; cmd_beats = CW'(nb); cmd_size = sz;
    cmd_wdata = wd; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic finish_wait();
    int t;
    t = 0;
    while (done_n == d0 && t < 300) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [AW-1:0] a, input logic w, input int nb,
                         input logic [2:0] sz, input logic [DW-1:0] wd);
    issue(a, w, nb, sz, wd);
    finish_wait();
  endtask

  task automatic clear_fault();
    flt_clear = 1'b1;
    @(negedge clk);
    flt_clear = 1'b0;
    chk("R8 flt_valid after clear", flt_valid, 0);
    bad_en = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 htrans idle", htrans, 2'b00);
    chk("R1 busy low", cmd_busy, 0);
    chk("R1 done low", cmd_done, 0);
    chk("R1 fault low", flt_valid, 0);
    chk("R12 hprot", hprot, 4'b0011);
  endtask

  task automatic t_write_burst();
    run_cmd(32'h10, 1'b1, 4, 3'd2, 32'h5500);
    chk("R2 beat count", log_n - lg0, 4);
    chk("R2 first NONSEQ", lg_trans[lg0], 2'b10);
    chk("R2 INCR code", lg_burst[lg0], 3'b001);
    for (int k = 0; k < 4; k++) begin
      chk("R3 burst addr", lg_addr[lg0 + k], 32'h10 + 4 * k);
      if (k > 0) chk("R3 SEQ type", lg_trans[lg0 + k], 2'b11);
      chk("R4 write data", mem[4 + k], 32'h5500 + k);
    end
    chk("R9 one done", done_n - d0, 1);
    chk("R9 ok status", done_err, 0);
  endtask

  task automatic t_read_wait();
    waits = 2;
    run_cmd(32'h20, 1'b0, 3, 3'd2, '0);
    waits = 0;
    chk("R3 beats under waits", log_n - lg0, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R3 addr under waits", lg_addr[lg0 + k], 32'h20 + 4 * k);
      chk("R5 read data", rd_buf[k], mem[8 + k]);
    end
    chk("R5 read beat count", rd_n - r0, 3);
    chk("R9 read ok", done_err, 0);
  endtask

  task automatic t_single();
    issue(32'h31, 1'b1, 1, 3'd0, 32'hC3);
    chk("R2 NONSEQ after accept", htrans, 2'b10);
    chk("R2 start address", haddr, 32'h31);
    chk("R2 SINGLE code", hburst, 3'b000);
    chk("R2 size", hsize, 3'd0);
    chk("R2 direction", hwrite, 1);
    chk("R2 busy", cmd_busy, 1);
    finish_wait();
    chk("R4 single write", mem[12], 32'hC3);
    chk("R9 single done", done_n - d0, 1);
  endtask

  task automatic t_half_read();
    run_cmd(32'h08, 1'b0, 2, 3'd1, '0);
    chk("R3 half step 0", lg_addr[lg0], 32'h08);
    chk("R3 half step 1", lg_addr[lg0 + 1], 32'h0A);
    chk("R5 half data", rd_buf[1], mem[2]);
  endtask

  task automatic t_err_mid_write();
    logic [DW-1:0] old14, old15;
    int c0;
    old14 = mem[14]; old15 = mem[15]; c0 = cancel_n;
    bad_en = 1'b1; bad_addr = 32'h38;
    run_cmd(32'h30, 1'b1, 4, 3'd2, 32'h7700);
    chk("R7 beats issued", log_n - lg0, 3);
    chk("R6 cancel seen", cancel_n - c0, 1);
    chk("R6 IDLE in 2nd cycle", cancel_trans, 2'b00);
    chk("R7 beat0 stands", mem[12], 32'h7700);
    chk("R7 beat1 stands", mem[13], 32'h7701);
    chk("R7 errored beat inert", mem[14], old14);
    chk("R7 beat3 not issued", mem[15], old15);
    chk("R7 bus idle", htrans, 2'b00);
    chk("R8 fault valid", flt_valid, 1);
    chk("R8 fault addr", flt_addr, 32'h38);
    chk("R8 fault dir", flt_write, 1);
    chk("R8 fault beat", flt_beat, 2);
    chk("R9 one done", done_n - d0, 1);
    chk("R9 err status", done_err, 1);
  endtask

  task automatic t_blocked();
    int lb, db;
    lb = log_n; db = done_n;
    issue(32'h00, 1'b0, 2, 3'd2, '0);
    repeat (6) @(negedge clk);
    chk("R10 no transfer", log_n - lb, 0);
    chk("R10 not busy", cmd_busy, 0);
    chk("R10 no done", done_n - db, 0);
    chk("R8 record held", flt_addr, 32'h38);
    chk("R8 still valid", flt_valid, 1);
    clear_fault();
  endtask

  task automatic t_err_read_first();
    bad_en = 1'b1; bad_addr = 32'h00;
    run_cmd(32'h00, 1'b0, 3, 3'd2, '0);
    chk("R11 only beat0 issued", log_n - lg0, 1);
    chk("R11 no read data", rd_n - r0, 0);
    chk("R11 fault dir read", flt_write, 0);
    chk("R11 fault beat0", flt_beat, 0);
    chk("R11 fault addr", flt_addr, 32'h00);
    chk("R11 err status", done_err, 1);
    clear_fault();
  endtask

  task automatic t_err_last();
    bad_en = 1'b1; bad_addr = 32'h18;
    run_cmd(32'h10, 1'b0, 3, 3'd2, '0);
    chk("R5 earlier reads", rd_n - r0, 2);
    chk("R5 beat1 data", rd_buf[1], mem[5]);
    chk("R8 last beat index", flt_beat, 2);
    chk("R7 beats issued", log_n - lg0, 3);
    clear_fault();
  endtask

  task automatic t_after_clear();
    run_cmd(32'h04, 1'b0, 1, 3'd2, '0);
    chk("R10 accepted after clear", done_n - d0, 1);
    chk("R10 ok status", done_err, 0);
    chk("R5 data after clear", rd_buf[0], mem[1]);
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; flt_clear = 1'b0; cmd_write = 1'b0;
    cmd_addr = '0; cmd_beats = '0; cmd_size = '0; cmd_wdata = '0;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write_burst();
    t_read_wait();
    t_single();
    t_half_read();
    t_err_mid_write();
    t_blocked();
    t_err_read_first();
    t_err_last();
    t_after_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule